// File: doc/BRIEF.md
# Descriptor Chain Walker for Scatter-Gather DMA

This block follows a singly linked chain of 16-byte scatter-gather descriptors stored in a local descriptor memory. It reads each descriptor as four 32-bit words through a one-cycle-latency read port. It then raises one transfer request toward a data mover, carrying the buffer address, the byte count, the direction, the ordering hint and the transfer mode. The request stays up until the mover completes it, and then the walker moves on to the entry named by the descriptor's link word.

A walk starts with a single-cycle `start` pulse and a byte pointer to the first descriptor. It ends with a one-cycle `done` pulse after the entry carrying the end flag completes. It ends instead with a one-cycle `error` pulse when a pointer is unusable. Descriptors are checked before they are issued, so a broken link never produces a request for the entry that holds it.

Descriptor layout, with words being little-endian 32-bit values at byte offsets 0, 4, 8 and 12:

- word 0: buffer address
- word 1: length in 8-byte units
- word 2 bits [7:0]: flags
- word 2 bits [11:8]: mode
- word 3: link pointer

Top module: `prd_walker`

## Requirements
- R1: After synchronous reset, `busy`, `xfer_req`, `done`, `error` and `mem_rd` are all low.
- R2: A `start` with an aligned pointer P makes the walker read word addresses P/4 to P/4+3. It then raises `xfer_req` with `xfer_addr` equal to word 0 and `xfer_bytes` equal to word 1 shifted left by 3, as a 35-bit value.
- R3: `xfer_ordered` equals word 2 bit 4, `xfer_write` equals word 2 bit 5, and `xfer_mode` equals word 2 bits [11:8]. Bits [31:12] and the upper half of the mode byte are ignored.
- R4: Only one request is outstanding at a time. `xfer_req` and all request fields hold steady until a cycle with `xfer_done` high, and no descriptor read happens while a request is up.
- R5: Entries are issued in link order, with the next entry's byte pointer taken from word 3. An entry with word 2 bit 7 set ends the walk, and its link word is ignored. `done` pulses for one cycle in the cycle after the final `xfer_done`.
- R6: A length field of 0 is issued as a request with `xfer_bytes` = 0, and the chain still advances.
- R7: A first pointer whose low 3 bits are not zero gives an `error` pulse in the cycle after `start`. No request is raised for it.
- R8: An entry without the end flag whose link word is zero, has its low 3 bits non-zero, or has bits at or above ADDR_W set, gives an `error` pulse and is not issued. Entries issued before it complete normally.
- R9: `start` is ignored while `busy` is high, and the walk in progress continues unchanged.
- R10: `done` and `error` are never high together, each lasts one cycle, and `busy` is low in the cycle after either.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (sampled when idle) |
| first_ptr | input | ADDR_W | Byte pointer to the first descriptor |
| busy | output | 1 | Walk in progress |
| mem_rd | output | 1 | Descriptor memory read strobe |
| mem_addr | output | ADDR_W-2 | Descriptor memory word address |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| xfer_req | output | 1 | Transfer request, held until completion |
| xfer_addr | output | 32 | Buffer address of the request |
| xfer_bytes | output | 35 | Byte count of the request |
| xfer_write | output | 1 | Direction toward the device |
| xfer_ordered | output | 1 | Ordering flag of the entry |
| xfer_mode | output | 4 | Transfer mode of the entry |
| xfer_done | input | 1 | Completion of the outstanding request |
| done | output | 1 | One-cycle pulse at the end of a good walk |
| error | output | 1 | One-cycle pulse on a bad pointer |

## Verification
The embedded properties assume that `xfer_done` arrives only while `xfer_req` is high. They also assume that the memory returns data exactly one cycle after each read strobe. The bench raises completion only in a cycle where it has already seen the request up, and its memory model registers read data on the strobe edge. Under those conditions, the checks that requests stay stable and that `done` follows a completion can be stated cycle by cycle.

// File: rtl/prd_walker_pkg.sv
package prd_walker_pkg;
  localparam int WORD_W    = 32;
  localparam int PRD_WORDS = 4;
  localparam int FLAG_ORD  = 4;
  localparam int FLAG_WR   = 5;
  localparam int FLAG_END  = 7;
  localparam int MODE_LSB  = 8;
  localparam int MODE_W    = 4;
  localparam int BYTES_W   = WORD_W + 3;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_FETCH = 2'd1,
    W_XFER  = 2'd2
  } walk_state_e;

  function automatic logic is_aligned8(input logic [2:0] low);
    return low == 3'b000;
  endfunction
endpackage

// File: rtl/prd_fetch.sv
module prd_fetch
  import prd_walker_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 go,
  input  logic [ADDR_W-1:0]                    base,
  output logic                                 mem_rd,
  output logic [ADDR_W-3:0]                    mem_addr,
  input  logic [WORD_W-1:0]                    mem_rdata,
  output logic                                 fetched,
  output logic [PRD_WORDS-1:0][WORD_W-1:0]     words
);
  localparam int IDX_W = $clog2(PRD_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PRD_WORDS - 1);

  logic             rd_q;
  logic [ADDR_W-3:0] addr_q;
  logic [IDX_W-1:0] idx_q;
  logic             cap_vld_q;
  logic [IDX_W-1:0] cap_idx_q;
  logic             fetched_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= 1'b0;
      addr_q    <= '0;
      idx_q     <= '0;
      cap_vld_q <= 1'b0;
      cap_idx_q <= '0;
      fetched_q <= 1'b0;
    end else begin
      fetched_q <= 1'b0;
      cap_vld_q <= rd_q;
      cap_idx_q <= idx_q;
      if (go) begin
        rd_q   <= 1'b1;
        idx_q  <= '0;
        addr_q <= base[ADDR_W-1:2];
      end else if (rd_q) begin
        if (idx_q == LAST_IDX) begin
          rd_q <= 1'b0;
        end else begin
          idx_q  <= idx_q + 1'b1;
          addr_q <= addr_q + 1'b1;
        end
      end
      if (cap_vld_q && cap_idx_q == LAST_IDX) fetched_q <= 1'b1;
    end
  end

  // Word capture registers, one per descriptor word
  for (genvar g = 0; g < PRD_WORDS; g++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst) words[g] <= '0;
      else if (cap_vld_q && cap_idx_q == IDX_W'(g)) words[g] <= mem_rdata;
    end
  end

  assign mem_rd   = rd_q;
  assign mem_addr = addr_q;
  assign fetched  = fetched_q;

  // R2: consecutive read strobes step through consecutive words
  a_r2_word_step: assert property (@(posedge clk) disable iff (rst)
    mem_rd && $past(mem_rd) |-> mem_addr == $past(mem_addr) + 1'b1);
endmodule

// File: rtl/prd_link_check.sv
module prd_link_check
  import prd_walker_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [WORD_W-1:0] ptr,
  output logic              ok
);
  logic in_range;

  if (ADDR_W < WORD_W) begin : g_range
    assign in_range = (ptr[WORD_W-1:ADDR_W] == '0);
  end else begin : g_full
    assign in_range = 1'b1;
  end

  assign ok = (ptr != '0) && is_aligned8(ptr[2:0]) && in_range;
endmodule

// File: rtl/prd_walker.sv
module prd_walker
  import prd_walker_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [ADDR_W-1:0]   first_ptr,
  output logic                busy,
  output logic                mem_rd,
  output logic [ADDR_W-3:0]   mem_addr,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic                xfer_req,
  output logic [WORD_W-1:0]   xfer_addr,
  output logic [BYTES_W-1:0]  xfer_bytes,
  output logic                xfer_write,
  output logic                xfer_ordered,
  output logic [MODE_W-1:0]   xfer_mode,
  input  logic                xfer_done,
  output logic                done,
  output logic                error
);
  walk_state_e               state_q;
  logic [ADDR_W-1:0]         cur_ptr_q;
  logic                      go_q;
  logic                      req_q;
  logic                      last_q;
  logic [ADDR_W-1:0]         next_q;
  logic                      done_q;
  logic                      err_q;
  logic [WORD_W-1:0]         addr_q;
  logic [BYTES_W-1:0]        bytes_q;
  logic                      wr_q;
  logic                      ord_q;
  logic [MODE_W-1:0]         mode_q;

  logic                                fetched;
  logic [PRD_WORDS-1:0][WORD_W-1:0]    words;
  logic                                link_ok;
  logic                                ent_last;

  prd_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk      (clk),
    .rst      (rst),
    .go       (go_q),
    .base     (cur_ptr_q),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .mem_rdata(mem_rdata),
    .fetched  (fetched),
    .words    (words)
  );

  prd_link_check #(.ADDR_W(ADDR_W)) u_link (
    .ptr(words[3]),
    .ok (link_ok)
  );

  assign ent_last = words[2][FLAG_END];

  logic unused_bits;
  assign unused_bits = ^{words[2][WORD_W-1:MODE_LSB+MODE_W], words[2][FLAG_END-1],
                         words[2][FLAG_ORD-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= W_IDLE;
      cur_ptr_q <= '0;
      go_q      <= 1'b0;
      req_q     <= 1'b0;
      last_q    <= 1'b0;
      next_q    <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      addr_q    <= '0;
      bytes_q   <= '0;
      wr_q      <= 1'b0;
      ord_q     <= 1'b0;
      mode_q    <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      go_q   <= 1'b0;
      unique case (state_q)
        W_IDLE: begin
          if (start) begin
            if (!is_aligned8(first_ptr[2:0])) begin
              err_q <= 1'b1;
            end else begin
              cur_ptr_q <= first_ptr;
              go_q      <= 1'b1;
              state_q   <= W_FETCH;
            end
          end
        end
        W_FETCH: begin
          if (fetched) begin
            if (!ent_last && !link_ok) begin
              err_q   <= 1'b1;
              state_q <= W_IDLE;
            end else begin
              addr_q  <= words[0];
              bytes_q <= {words[1], 3'b000};
              wr_q    <= words[2][FLAG_WR];
              ord_q   <= words[2][FLAG_ORD];
              mode_q  <= words[2][MODE_LSB +: MODE_W];
              last_q  <= ent_last;
              next_q  <= words[3][ADDR_W-1:0];
              req_q   <= 1'b1;
              state_q <= W_XFER;
            end
          end
        end
        W_XFER: begin
          if (xfer_done) begin
            req_q <= 1'b0;
            if (last_q) begin
              done_q  <= 1'b1;
              state_q <= W_IDLE;
            end else begin
              cur_ptr_q <= next_q;
              go_q      <= 1'b1;
              state_q   <= W_FETCH;
            end
          end
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

  assign busy         = (state_q != W_IDLE);
  assign xfer_req     = req_q;
  assign xfer_addr    = addr_q;
  assign xfer_bytes   = bytes_q;
  assign xfer_write   = wr_q;
  assign xfer_ordered = ord_q;
  assign xfer_mode    = mode_q;
  assign done         = done_q;
  assign error        = err_q;

  // R4: request and its fields hold until completion
  a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
    xfer_req && !xfer_done |=> xfer_req && $stable(xfer_addr) && $stable(xfer_bytes)
      && $stable(xfer_mode) && $stable(xfer_write));
  // R4: no descriptor read while a request is outstanding
  a_r4_no_read_in_xfer: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> !mem_rd);
  // R5: completion pulse follows an accepted transfer
  a_r5_done_after_xfer: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(xfer_req && xfer_done));
  // R7: an error never coexists with a live request
  a_r7_err_no_req: assert property (@(posedge clk) disable iff (rst)
    error |-> !xfer_req);
  // R10: terminal pulses are exclusive and single-cycle
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && error));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && !busy);
  a_r10_err_pulse: assert property (@(posedge clk) disable iff (rst)
    error |=> !error && !busy);
endmodule

// File: tb/test_prd_walker.sv
module test_prd_walker;
  import prd_walker_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  typedef struct packed {
    logic [AW-1:0] ptr;
    logic [31:0]   addr;
    logic [31:0]   units;
    logic [7:0]    flags;
    logic [3:0]    mode;
    logic [31:0]   next;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VEC [NV] = '{
    '{10'h040, 32'h1000_0000, 32'h0000_0010, 8'h10, 4'h2, 32'h0000_0100},
    '{10'h100, 32'h2345_6780, 32'h0000_0000, 8'h30, 4'hF, 32'h0000_00A8},
    '{10'h0A8, 32'hDEAD_BEE8, 32'h1FFF_FFFF, 8'h20, 4'h5, 32'h0000_0200},
    '{10'h200, 32'h0000_0008, 32'h0000_0001, 8'h00, 4'h0, 32'h0000_03F0},
    '{10'h3F0, 32'hFFFF_FFF8, 32'hFFFF_FFFF, 8'h90, 4'h9, 32'h0000_0008}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] first_ptr = '0;
  logic busy, mem_rd, xfer_req, xfer_write, xfer_ordered, done, error;
  logic [AW-3:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic [31:0] xfer_addr;
  logic [BYTES_W-1:0] xfer_bytes;
  logic [3:0] xfer_mode;
  logic xfer_done = 1'b0;

  logic [31:0] mem [256];

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  prd_walker #(.ADDR_W(AW)) i_prd_walker (
    .clk(clk), .rst(rst), .start(start), .first_ptr(first_ptr), .busy(busy),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_bytes(xfer_bytes),
    .xfer_write(xfer_write), .xfer_ordered(xfer_ordered), .xfer_mode(xfer_mode),
    .xfer_done(xfer_done), .done(done), .error(error)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_prd(input logic [AW-1:0] p, input logic [31:0] a,
                         input logic [31:0] u, input logic [7:0] f,
                         input logic [3:0] m, input logic [31:0] nx);
    int w = int'(p) >> 2;
    mem[w]   = a;
    mem[w+1] = u;
    mem[w+2] = {8'hA5, 8'h3C, 4'hC, m, f};
    mem[w+3] = nx;
  endtask

  task automatic wait_req(output bit seen);
    seen = 0;
    for (int k = 0; k < 40 && !seen; k++) begin
      if (xfer_req) seen = 1;
      else @(negedge clk);
    end
  endtask

  task automatic expect_error(input logic [AW-1:0] p, input int exp_req, input string tag);
    int nreq = 0;
    bit got = 0;
    bit gotdone = 0;
    first_ptr = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 80 && !got; k++) begin
      if (error) got = 1;
      if (done) gotdone = 1;
      if (xfer_req && !xfer_done) begin
        nreq++;
        xfer_done = 1'b1;
      end else begin
        xfer_done = 1'b0;
      end
      if (!got) @(negedge clk);
    end
    xfer_done = 1'b0;
    chk(got, {tag, " error pulse"}, 64'(got), 64'd1);
    chk(nreq == exp_req, {tag, " requests issued"}, 64'(nreq), 64'(exp_req));
    chk(!gotdone, {tag, " no done"}, 64'(gotdone), 64'd0);
    @(negedge clk);
    chk(!busy && !error, {tag, " R10 idle after error"}, 64'({busy, error}), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit seen;
    for (int k = 0; k < 256; k++) mem[k] = 32'h0;
    for (int i = 0; i < NV; i++)
      put_prd(VEC[i].ptr, VEC[i].addr, VEC[i].units, VEC[i].flags, VEC[i].mode, VEC[i].next);

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !xfer_req && !done && !error && !mem_rd, "R1 reset outputs",
        64'({busy, xfer_req, done, error, mem_rd}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_rd, "R1 idle after reset", 64'({busy, mem_rd}), 64'd0);

    // Main chain walked from the vector table: R2 R3 R5 R6 R9
    first_ptr = VEC[0].ptr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R2 busy after start", 64'(busy), 64'd1);
    for (int i = 0; i < NV; i++) begin
      wait_req(seen);
      chk(seen, "R5 request in chain order", 64'(seen), 64'd1);
      chk(xfer_addr == VEC[i].addr, "R2 xfer_addr", 64'(xfer_addr), 64'(VEC[i].addr));
      chk(xfer_bytes == {VEC[i].units, 3'b000}, "R2 R6 xfer_bytes",
          64'(xfer_bytes), 64'({VEC[i].units, 3'b000}));
      chk(xfer_write == VEC[i].flags[5], "R3 xfer_write", 64'(xfer_write), 64'(VEC[i].flags[5]));
      chk(xfer_ordered == VEC[i].flags[4], "R3 xfer_ordered",
          64'(xfer_ordered), 64'(VEC[i].flags[4]));
      chk(xfer_mode == VEC[i].mode, "R3 xfer_mode", 64'(xfer_mode), 64'(VEC[i].mode));
      for (int d = 0; d < (i % 3) + 1; d++) begin
        if (i == 1 && d == 0) begin
          first_ptr = 10'h300;
          start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        chk(xfer_req && xfer_addr == VEC[i].addr, "R4 request held", 64'(xfer_addr),
            64'(VEC[i].addr));
      end
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
      chk(!xfer_req, "R4 request dropped after completion", 64'(xfer_req), 64'd0);
      chk(done == (i == NV - 1), "R5 done only after end entry", 64'(done),
          64'(i == NV - 1));
      chk(!error, "R9 no error from ignored start", 64'(error), 64'd0);
    end
    @(negedge clk);
    chk(!busy && !done, "R10 idle after done", 64'({busy, done}), 64'd0);

    // R7 misaligned first pointer
    expect_error(10'h044, 0, "R7 misaligned first");
    expect_error(10'h3FC, 0, "R7 misaligned first high");

    // R8 bad links in non-last entries
    put_prd(10'h300, 32'h1111_1110, 32'h4, 8'h00, 4'h1, 32'h0000_0000);
    expect_error(10'h300, 0, "R8 zero link");
    put_prd(10'h310, 32'h2222_2220, 32'h4, 8'h10, 4'h1, 32'h0000_030C);
    expect_error(10'h310, 0, "R8 misaligned link");
    put_prd(10'h320, 32'h3333_3330, 32'h4, 8'h20, 4'h1, 32'h0001_0000);
    expect_error(10'h320, 0, "R8 out-of-range link");
    put_prd(10'h330, 32'h4444_4440, 32'h2, 8'h00, 4'h3, 32'h0000_0340);
    put_prd(10'h340, 32'h5555_5550, 32'h2, 8'h00, 4'h3, 32'h0000_0004);
    expect_error(10'h330, 1, "R8 bad link after good entry");

    // R5 R6 single last entry with zero length and junk link
    put_prd(10'h350, 32'h6666_6660, 32'h0, 8'hB0, 4'h7, 32'hFFFF_FFFF);
    first_ptr = 10'h350;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_req(seen);
    chk(seen && xfer_bytes == '0, "R6 zero-length single entry", 64'(xfer_bytes), 64'd0);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    chk(done && !error, "R5 end flag ignores link", 64'({done, error}), 64'd2);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule